// File: doc/BRIEF.md
# Trace Buffer Readout Gate

After a capture session, this block lets software read a circular trace buffer one line at a time through a single data register. It decides whether each read may return real data. It keeps the buffer locked from the moment the module is armed. It also walks a read pointer so that lines come out oldest-first. The memory sits outside the block: it presents the line addressed by `rd_ptr` on `line_data`, and the block returns that line on a permitted read.

A read session begins with the first permitted read after arming. Its start line is computed from the capture side's rollover flag and write pointer. The line-count output shows how many lines hold valid data, and reading does not reduce it. Byte-wide and misaligned reads are answered with zero and are otherwise ignored.

The bus side uses plain strobes, because readout is register access and not a stream. A read or write is a single-cycle pulse with no back-pressure, and it is never stalled.

Top module: `trace_readout_ctrl`

## Requirements
- R1: A word read of the data register returns the current line only when `arm` is 0, `tsrc_en` is 1, `secure` is 0 and the buffer is unlocked. Otherwise it returns zero and leaves the pointer where it was.
- R2: Any cycle with `arm` at 1 locks the buffer. The lock stays in place after `arm` returns to 0.
- R3: Only a write to the data register with `bus_be` = 2'b11 and `bus_addr[0]` = 0, made while `arm` is 0, clears the lock. A byte write, a misaligned write, or a write made while armed leaves the buffer locked.
- R4: A read of the data register is a word read only when `bus_be` = 2'b11 and `bus_addr[0]` = 0. Any other read of it (byte enables 2'b01 or 2'b10, or address bit 0 set) returns zero and does not move the pointer. The register occupies even byte address `TB_ADDR` and the odd address above it.
- R5: Each granted read returns the line at `rd_ptr` and then advances the pointer by one, wrapping from DEPTH-1 to 0. Lines therefore come out in the order they were written.
- R6: Before the first granted read of a session, `rd_ptr` shows the start line. This is 0 when `rollover` is 0 and `wr_ptr` when `rollover` is 1.
- R7: `line_cnt` equals `wr_ptr` when `rollover` is 0 and DEPTH when it is 1. Reads never decrement it.
- R8: Any cycle with `arm` at 1 ends the current session, so `rd_ptr` again shows the start line computed under R6.
- R9: After reset, `rd_data` is 0, the buffer is unlocked and no session is open. `rd_data` changes only on a read of the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the access |
| bus_be | input | 2 | Byte enables, 2'b11 for a full word |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| arm | input | 1 | Module armed for capture |
| tsrc_en | input | 1 | Trace source enabled |
| secure | input | 1 | System is secured |
| rollover | input | 1 | Capture wrapped around the buffer |
| wr_ptr | input | log2(DEPTH) | Next line the capture side would write |
| line_data | input | DW | Buffer line addressed by `rd_ptr` |
| rd_data | output | DW | Data register read value |
| line_cnt | output | log2(DEPTH+1) | Number of valid lines |
| rd_ptr | output | log2(DEPTH) | Line the next granted read returns |

## Verification
`rd_data`, `rd_ptr` and the lock all update on the first rising edge after a strobe or an `arm` cycle. `line_cnt`, and `rd_ptr` while no session is open, follow `rollover` and `wr_ptr` within the same cycle. Each strobe is driven on a falling edge and held for one cycle. Its result is sampled on the next falling edge, half a cycle after the edge that registers it. Lock state is observed only through what the next word read returns.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_BAD  = 2'd2
  } acc_e;
endpackage

// File: rtl/tbr_access_decode.sv
module tbr_access_decode #(
  parameter int AW = 8,
  parameter logic [AW-1:0] TB_ADDR = 8'h2E
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    be,
  input  logic          strobe,
  output tbr_pkg::acc_e acc
);
  import tbr_pkg::*;
  logic hit, whole;
  assign hit   = (addr[AW-1:1] == TB_ADDR[AW-1:1]);
  assign whole = (be == 2'b11) && !addr[0];
  always_comb begin
    if (!(strobe && hit)) acc = ACC_NONE;
    else if (whole)       acc = ACC_WORD;
    else                  acc = ACC_BAD;
  end
endmodule

// File: rtl/tbr_lock_ctrl.sv
module tbr_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic unlock_req,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b0;
    else if (arm)        locked <= 1'b1;
    else if (unlock_req) locked <= 1'b0;
  end
endmodule

// File: rtl/tbr_read_ptr.sv
module tbr_read_ptr #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             rollover,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             advance,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             live
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  logic [PTR_W-1:0] ptr_q, start, next;

  assign start  = rollover ? wr_ptr : '0;
  assign rd_ptr = live ? ptr_q : start;
  assign next   = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      live  <= 1'b0;
    end else if (arm) begin
      live  <= 1'b0;
    end else if (advance) begin
      ptr_q <= next;
      live  <= 1'b1;
    end
  end
endmodule

// File: rtl/trace_readout_ctrl.sv
module trace_readout_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] TB_ADDR = 8'h2E
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [AW-1:0]              bus_addr,
  input  logic [1:0]                 bus_be,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic                       arm,
  input  logic                       tsrc_en,
  input  logic                       secure,
  input  logic                       rollover,
  input  logic [$clog2(DEPTH)-1:0]   wr_ptr,
  input  logic [DW-1:0]              line_data,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0] line_cnt,
  output logic [$clog2(DEPTH)-1:0]   rd_ptr
);
  import tbr_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  acc_e rd_acc, wr_acc;
  logic locked, live, grant, unlock_req;

  tbr_access_decode #(.AW(AW), .TB_ADDR(TB_ADDR)) u_rd_dec (
    .addr(bus_addr), .be(bus_be), .strobe(bus_rd), .acc(rd_acc));
  tbr_access_decode #(.AW(AW), .TB_ADDR(TB_ADDR)) u_wr_dec (
    .addr(bus_addr), .be(bus_be), .strobe(bus_wr), .acc(wr_acc));

  assign unlock_req = (wr_acc == ACC_WORD) && !arm;

  tbr_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .arm(arm), .unlock_req(unlock_req), .locked(locked));

  assign grant = (rd_acc == ACC_WORD) && !arm && tsrc_en && !secure && !locked;

  tbr_read_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .rollover(rollover), .wr_ptr(wr_ptr),
    .advance(grant), .rd_ptr(rd_ptr), .live(live));

  assign line_cnt = rollover ? CNT_W'(DEPTH) : CNT_W'(wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_data <= '0;
    else if (rd_acc != ACC_NONE) rd_data <= grant ? line_data : '0;
  end
endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
  parameter int DEPTH = 16,
  parameter int DW = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       arm,
  input logic                       tsrc_en,
  input logic                       secure,
  input logic                       rollover,
  input logic [$clog2(DEPTH)-1:0]   wr_ptr,
  input tbr_pkg::acc_e              rd_acc,
  input tbr_pkg::acc_e              wr_acc,
  input logic                       locked,
  input logic                       live,
  input logic                       grant,
  input logic [DW-1:0]              rd_data,
  input logic [$clog2(DEPTH+1)-1:0] line_cnt,
  input logic [$clog2(DEPTH)-1:0]   rd_ptr
);
  import tbr_pkg::*;
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  assert_read_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc == ACC_WORD && (arm || secure || !tsrc_en || locked)) |=> rd_data == '0);

  assert_arm_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> locked);

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(wr_acc == ACC_WORD && !arm)) |=> locked);

  assert_bad_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc == ACC_BAD) |=> rd_data == '0);

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !grant && !arm) |=> rd_ptr == $past(rd_ptr));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1));

  assert_cnt_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rollover) && $stable(wr_ptr)) |-> $stable(line_cnt));

  assert_arm_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !live);
endmodule

bind trace_readout_ctrl tbr_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .tsrc_en(tsrc_en), .secure(secure),
  .rollover(rollover), .wr_ptr(wr_ptr), .rd_acc(rd_acc), .wr_acc(wr_acc),
  .locked(locked), .live(live), .grant(grant), .rd_data(rd_data),
  .line_cnt(line_cnt), .rd_ptr(rd_ptr));

// File: tb/tb_trace_readout_ctrl.sv
module tb_trace_readout_ctrl;
  localparam int DEPTH = 16;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] REG = 8'h2E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = REG;
  logic [1:0] bus_be = 2'b11;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic arm = 1'b0, tsrc_en = 1'b1, secure = 1'b0, rollover = 1'b0;
  logic [3:0] wr_ptr = 4'd9;
  logic [DW-1:0] line_data, rd_data;
  logic [4:0] line_cnt;
  logic [3:0] rd_ptr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign line_data = 16'h5A00 | {12'h000, rd_ptr};

  trace_readout_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TB_ADDR(REG)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .arm(arm), .tsrc_en(tsrc_en),
    .secure(secure), .rollover(rollover), .wr_ptr(wr_ptr),
    .line_data(line_data), .rd_data(rd_data), .line_cnt(line_cnt), .rd_ptr(rd_ptr));

  typedef struct packed {
    logic [1:0]  be;
    logic [7:0]  addr;
    logic        sec;
    logic        tsrc;
    logic [15:0] exp_data;
    logic [3:0]  exp_ptr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b11, 8'h2E, 1'b0, 1'b1, 16'h5A05, 4'd6},
    '{2'b01, 8'h2E, 1'b0, 1'b1, 16'h0000, 4'd6},
    '{2'b11, 8'h2F, 1'b0, 1'b1, 16'h0000, 4'd6},
    '{2'b11, 8'h2E, 1'b0, 1'b1, 16'h5A06, 4'd7},
    '{2'b11, 8'h2E, 1'b1, 1'b1, 16'h0000, 4'd7},
    '{2'b11, 8'h2E, 1'b0, 1'b0, 16'h0000, 4'd7},
    '{2'b11, 8'h2E, 1'b0, 1'b1, 16'h5A07, 4'd8}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] be);
    @(negedge clk); bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; bus_addr = REG; bus_be = 2'b11;
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] be);
    @(negedge clk); bus_addr = a; bus_be = be; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = REG; bus_be = 2'b11;
  endtask

  task automatic arm_pulse();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state, R6 start line without rollover, R7 count
    chk("R9 rd_data after reset", rd_data, 0);
    chk("R6 start ptr no rollover", rd_ptr, 0);
    chk("R7 count no rollover", line_cnt, 9);
    rst_n = 1'b1;
    @(negedge clk);
    rollover = 1'b1; wr_ptr = 4'd5;
    #1;
    chk("R6 start ptr with rollover", rd_ptr, 5);
    chk("R7 count with rollover", line_cnt, 16);

    // R1 R4 R5 table walk
    foreach (VECS[i]) begin
      @(negedge clk);
      secure = VECS[i].sec; tsrc_en = VECS[i].tsrc;
      rd(VECS[i].addr, VECS[i].be);
      chk($sformatf("R1/R4/R5 vec%0d data", i), rd_data, VECS[i].exp_data);
      chk($sformatf("R1/R4/R5 vec%0d ptr", i), rd_ptr, VECS[i].exp_ptr);
      secure = 1'b0; tsrc_en = 1'b1;
    end
    chk("R7 count not decremented", line_cnt, 16);

    // R8 arm restarts session; R1 armed read is zero
    @(negedge clk); arm = 1'b1;
    @(negedge clk);
    chk("R8 ptr back to start", rd_ptr, 5);
    bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R1 read while armed", rd_data, 0);
    arm = 1'b0;

    // R2 lock persists after disarm
    rd(REG, 2'b11);
    chk("R2 locked read zero", rd_data, 0);
    chk("R2 locked read ptr", rd_ptr, 5);
    // R3 byte write keeps lock
    wr(REG, 2'b10);
    rd(REG, 2'b11);
    chk("R3 byte write no unlock", rd_data, 0);
    // R3 misaligned write keeps lock
    wr(8'h2F, 2'b11);
    rd(REG, 2'b11);
    chk("R3 misaligned write no unlock", rd_data, 0);
    // R3 write while armed keeps lock
    @(negedge clk); arm = 1'b1; bus_wr = 1'b1;
    @(negedge clk); arm = 1'b0; bus_wr = 1'b0;
    rd(REG, 2'b11);
    chk("R3 armed write no unlock", rd_data, 0);
    // R3 aligned word write unlocks
    wr(REG, 2'b11);
    rd(REG, 2'b11);
    chk("R3 unlock then read", rd_data, 16'h5A05);
    chk("R5 ptr after unlock read", rd_ptr, 6);

    // R6 new session without rollover starts at line 0
    rollover = 1'b0; wr_ptr = 4'd9;
    arm_pulse();
    wr(REG, 2'b11);
    chk("R6 ptr start line0", rd_ptr, 0);
    chk("R7 count 9", line_cnt, 9);
    rd(REG, 2'b11);
    chk("R6 first line", rd_data, 16'h5A00);

    // R5 wrap from last line
    rollover = 1'b1; wr_ptr = 4'd15;
    arm_pulse();
    wr(REG, 2'b11);
    rd(REG, 2'b11);
    chk("R5 last line data", rd_data, 16'h5A0F);
    chk("R5 wrap ptr", rd_ptr, 0);
    rd(REG, 2'b11);
    chk("R5 after wrap data", rd_data, 16'h5A00);
    // R9 read of another address leaves rd_data
    rd(8'h10, 2'b11);
    chk("R9 other address holds data", rd_data, 16'h5A00);
    chk("R9 other address ptr", rd_ptr, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule